// File: doc/BRIEF.md
# Attack Event Monitor

The block gathers attack indications from a set of bus firewalls. Each firewall drives its own single-bit line into the monitor, apart from the system bus. A pulse on a line marks that firewall as pending in a summary register and adds one to a per-firewall event counter. The event is also stamped with the current value of a free-running timer and queued into a small log. A supervisor reacts to an interrupt. It services the pending firewalls in a fixed order given by their bit positions and clears each one once handled.

Registers are read through a plain address/data read port with one cycle of latency. The log is a first-in first-out queue whose head is presented on dedicated outputs and advanced by a pop strobe. When several firewalls are pending, the service index output names the one to handle next. That is always the lowest-numbered pending firewall, which is also the order in which the firewalls get blocked.

Top module: `aem_monitor`

## Requirements
- R1: Summary bit i (read address 0, bit i) becomes 1 one cycle after a pulse on attack line i and stays 1 until a clear strobe with mask bit i set. A pulse and a clear of the same bit in the same cycle leave the bit at 1.
- R2: The interrupt output is 1 exactly when the global interrupt enable input is 1 and at least one summary bit is 1.
- R3: The service-valid output is 1 when any summary bit is 1. The service index then equals the lowest set summary bit position.
- R4: Each firewall has an 8-bit event counter at read address 4+i. It adds one in every cycle its attack line is high and saturates at 255.
- R5: The timer at read address 1 starts at 0 after reset and increases by exactly one per clock cycle.
- R6: Each accepted event yields one log entry holding the firewall index and the timer value from the cycle the pulse was sampled. Pulses sampled together enter the log one per cycle in ascending firewall index. The log head is shown on the log outputs, and a pop strobe removes it.
- R7: The log holds 16 entries. An event that finds the log full is dropped and sets a sticky overflow flag (read address 2, bit 0), which only the overflow-clear strobe resets.
- R8: Read data appears one cycle after the address. Read address 2 carries the log fill count in bits 15:8. Unmapped addresses (such as 3) read as 0.
- R9: After reset, all summary bits, counters, the log and the overflow flag are 0, and the interrupt is low.
- R10: A second pulse from a firewall whose earlier event has not yet moved into the log is dropped from the log and sets the overflow flag. The counter still counts it.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| atk_i | input | NUM_FW | Attack lines, one per firewall |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request to the supervisor |
| svc_valid_o | output | 1 | Some firewall is pending |
| svc_idx_o | output | IDX_W | Next firewall to service |
| clr_we_i | input | 1 | Clear strobe for summary bits |
| clr_mask_i | input | NUM_FW | Write-1-to-clear mask |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | 32 | Register read data |
| log_valid_o | output | 1 | Log holds an entry |
| log_idx_o | output | IDX_W | Firewall index of the log head |
| log_ts_o | output | TS_W | Timestamp of the log head |
| log_pop_i | input | 1 | Remove the log head |
| ovf_clr_i | input | 1 | Clear the overflow flag |

## Verification
The hardest condition to reach is a log drop. It occurs either because the queue is full or because a firewall fires again while its earlier event still waits in staging behind lower-numbered firewalls. The bench reaches the first case by sending twenty spaced pulses with no pops. It reaches the second by pulsing all lines together and then pulsing the highest-numbered line again in the very next cycle. A sweep over every non-empty combination of simultaneous pulses checks the log ordering and the service index.

// File: rtl/aem_pkg.sv
package aem_pkg;
   localparam int unsigned RA_SUMMARY  = 0;
   localparam int unsigned RA_TIMER    = 1;
   localparam int unsigned RA_STATUS   = 2;
   localparam int unsigned RA_CNT_BASE = 4;
   localparam int unsigned RD_W        = 32;
   localparam int unsigned STAT_CNT_LSB = 8;
endpackage

// File: rtl/aem_timer.sv
module aem_timer #(
   parameter int unsigned TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ts_o <= '0;
      else        ts_o <= ts_o + 1'b1;
   end
endmodule

// File: rtl/aem_fw_slot.sv
module aem_fw_slot #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned TS_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             atk_i,
   input  logic             clr_i,
   input  logic [TS_W-1:0]  ts_i,
   input  logic             grant_i,
   output logic             pend_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             stg_v_o,
   output logic [TS_W-1:0]  stg_ts_o,
   output logic             drop_o
);
   logic load;

   assign load   = atk_i && (!stg_v_o || grant_i);
   assign drop_o = atk_i && stg_v_o && !grant_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
      end else if (atk_i) begin
         pend_o <= 1'b1;
      end else if (clr_i) begin
         pend_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (atk_i && (cnt_o != {CNT_W{1'b1}})) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v_o  <= 1'b0;
         stg_ts_o <= '0;
      end else if (load) begin
         stg_v_o  <= 1'b1;
         stg_ts_o <= ts_i;
      end else if (grant_i) begin
         stg_v_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/aem_prio.sv
module aem_prio #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/aem_log_fifo.sv
module aem_log_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 34,
   parameter int unsigned CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] din_i,
   input  logic          pop_i,
   output logic          valid_o,
   output logic [DW-1:0] dout_o,
   output logic          full_o,
   output logic [CW-1:0] count_o
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full_o  = (count_o == CW'(DEPTH));
   assign valid_o = (count_o != '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && valid_o;
   assign dout_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_o <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end
endmodule

// File: rtl/aem_monitor.sv
module aem_monitor #(
   parameter int unsigned NUM_FW    = 4,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TS_W      = 32,
   parameter int unsigned LOG_DEPTH = 16,
   localparam int unsigned IDX_W    = (NUM_FW > 1) ? $clog2(NUM_FW) : 1,
   localparam int unsigned AW       = $clog2(aem_pkg::RA_CNT_BASE + NUM_FW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_FW-1:0] atk_i,
   input  logic              irq_en_i,
   output logic              irq_o,
   output logic              svc_valid_o,
   output logic [IDX_W-1:0]  svc_idx_o,
   input  logic              clr_we_i,
   input  logic [NUM_FW-1:0] clr_mask_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [31:0]       rd_data_o,
   output logic              log_valid_o,
   output logic [IDX_W-1:0]  log_idx_o,
   output logic [TS_W-1:0]   log_ts_o,
   input  logic              log_pop_i,
   input  logic              ovf_clr_i
);
   import aem_pkg::*;

   localparam int unsigned LOG_DW = IDX_W + TS_W;
   localparam int unsigned LCNT_W = $clog2(LOG_DEPTH + 1);

   if (NUM_FW < 1 || NUM_FW > 32) begin : g_bad_nfw
      $error("NUM_FW must be within 1..32");
   end
   if (TS_W < 1 || TS_W > RD_W) begin : g_bad_tsw
      $error("TS_W must be within 1..32");
   end
   if (CNT_W < 1 || CNT_W > RD_W) begin : g_bad_cntw
      $error("CNT_W must be within 1..32");
   end
   if (LOG_DEPTH < 2 || (LOG_DEPTH & (LOG_DEPTH - 1)) != 0 || LCNT_W > 24) begin : g_bad_depth
      $error("LOG_DEPTH must be a power of two of reasonable size");
   end

   logic [TS_W-1:0]   ts;
   logic [NUM_FW-1:0] pend, stg_v, drop, grant;
   logic [TS_W-1:0]   stg_ts  [NUM_FW];
   logic [CNT_W-1:0]  cnt_arr [NUM_FW];
   logic              push_req, log_full, ovf_q;
   logic [IDX_W-1:0]  arb_idx;
   logic [LOG_DW-1:0] log_din, log_dout;
   logic [LCNT_W-1:0] log_cnt;
   logic [31:0]       rd_nx;

   aem_timer #(.TS_W(TS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .ts_o(ts)
   );

   for (genvar g = 0; g < NUM_FW; g++) begin : g_slot
      assign grant[g] = push_req && (arb_idx == IDX_W'(g));
      aem_fw_slot #(.CNT_W(CNT_W), .TS_W(TS_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .atk_i   (atk_i[g]),
         .clr_i   (clr_we_i && clr_mask_i[g]),
         .ts_i    (ts),
         .grant_i (grant[g]),
         .pend_o  (pend[g]),
         .cnt_o   (cnt_arr[g]),
         .stg_v_o (stg_v[g]),
         .stg_ts_o(stg_ts[g]),
         .drop_o  (drop[g])
      );
   end

   aem_prio #(.N(NUM_FW), .IDX_W(IDX_W)) u_svc (
      .req_i(pend), .any_o(svc_valid_o), .idx_o(svc_idx_o)
   );

   aem_prio #(.N(NUM_FW), .IDX_W(IDX_W)) u_arb (
      .req_i(stg_v), .any_o(push_req), .idx_o(arb_idx)
   );

   assign log_din = {arb_idx, stg_ts[arb_idx]};

   aem_log_fifo #(.DEPTH(LOG_DEPTH), .DW(LOG_DW), .CW(LCNT_W)) u_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push_req),
      .din_i  (log_din),
      .pop_i  (log_pop_i),
      .valid_o(log_valid_o),
      .dout_o (log_dout),
      .full_o (log_full),
      .count_o(log_cnt)
   );

   assign log_idx_o = log_dout[LOG_DW-1 -: IDX_W];
   assign log_ts_o  = log_dout[TS_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if ((|drop) || (push_req && log_full)) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr_i) begin
         ovf_q <= 1'b0;
      end
   end

   assign irq_o = irq_en_i && (|pend);

   always_comb begin
      rd_nx = '0;
      if (rd_addr_i == AW'(RA_SUMMARY)) rd_nx[NUM_FW-1:0] = pend;
      if (rd_addr_i == AW'(RA_TIMER))   rd_nx[TS_W-1:0]   = ts;
      if (rd_addr_i == AW'(RA_STATUS)) begin
         rd_nx[0] = ovf_q;
         rd_nx[STAT_CNT_LSB +: LCNT_W] = log_cnt;
      end
      for (int i = 0; i < NUM_FW; i++) begin
         if (rd_addr_i == AW'(RA_CNT_BASE + i)) rd_nx[CNT_W-1:0] = cnt_arr[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data_o <= '0;
      else        rd_data_o <= rd_nx;
   end
endmodule

// File: rtl/aem_monitor_chk.sv
module aem_monitor_chk #(
   parameter int unsigned NUM_FW    = 4,
   parameter int unsigned LOG_DEPTH = 16,
   parameter int unsigned IDX_W     = 2,
   parameter int unsigned LCNT_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_FW-1:0] atk_i,
   input logic              clr_we_i,
   input logic              irq_en_i,
   input logic              irq_o,
   input logic              svc_valid_o,
   input logic [IDX_W-1:0]  svc_idx_o,
   input logic [NUM_FW-1:0] pend,
   input logic              ovf_q,
   input logic              ovf_clr_i,
   input logic [LCNT_W-1:0] log_cnt
);
   logic [NUM_FW-1:0] below;

   always_comb begin
      below = '0;
      for (int j = 0; j < NUM_FW; j++) begin
         if (IDX_W'(j) < svc_idx_o) below[j] = 1'b1;
      end
   end

   p_sum_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|atk_i) |=> svc_valid_o);

   p_sum_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid_o && !clr_we_i) |=> svc_valid_o);

   p_irq_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && svc_valid_o) |-> irq_o);

   p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_i || !svc_valid_o) |-> !irq_o);

   p_svc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      svc_valid_o |-> (pend[svc_idx_o] && ((pend & below) == '0)));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr_i) |=> ovf_q);

   p_log_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      log_cnt <= LCNT_W'(LOG_DEPTH));
endmodule

bind aem_monitor aem_monitor_chk #(
   .NUM_FW(NUM_FW), .LOG_DEPTH(LOG_DEPTH), .IDX_W(IDX_W), .LCNT_W(LCNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .atk_i(atk_i), .clr_we_i(clr_we_i),
   .irq_en_i(irq_en_i), .irq_o(irq_o), .svc_valid_o(svc_valid_o),
   .svc_idx_o(svc_idx_o), .pend(pend), .ovf_q(ovf_q),
   .ovf_clr_i(ovf_clr_i), .log_cnt(log_cnt)
);

// File: tb/aem_monitor_test.sv
module aem_monitor_test;
   localparam int PERIOD = 10;
   localparam int NF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] atk_i = '0;
   logic          irq_en_i = 1'b0;
   logic          irq_o, svc_valid_o, log_valid_o;
   logic [1:0]    svc_idx_o, log_idx_o;
   logic          clr_we_i = 1'b0;
   logic [NF-1:0] clr_mask_i = '0;
   logic [2:0]    rd_addr_i = '0;
   logic [31:0]   rd_data_o;
   logic [31:0]   log_ts_o;
   logic          log_pop_i = 1'b0;
   logic          ovf_clr_i = 1'b0;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int exp_cnt [NF];
   int stamps [20];
   logic [31:0] d, d2;
   int t0;

   aem_monitor uut (
      .clk(clk), .rst_n(rst_n), .atk_i(atk_i), .irq_en_i(irq_en_i),
      .irq_o(irq_o), .svc_valid_o(svc_valid_o), .svc_idx_o(svc_idx_o),
      .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .log_valid_o(log_valid_o), .log_idx_o(log_idx_o),
      .log_ts_o(log_ts_o), .log_pop_i(log_pop_i), .ovf_clr_i(ovf_clr_i)
   );

   always #(PERIOD/2) clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      rd_addr_i = 3'(a);
      @(negedge clk);
      v = rd_data_o;
   endtask

   task automatic pulse(input logic [NF-1:0] m, output int st);
      atk_i = m;
      st = cyc;
      for (int i = 0; i < NF; i++) if (m[i] && exp_cnt[i] < 255) exp_cnt[i]++;
      @(negedge clk);
      atk_i = '0;
   endtask

   task automatic clear(input logic [NF-1:0] m);
      clr_we_i = 1'b1;
      clr_mask_i = m;
      @(negedge clk);
      clr_we_i = 1'b0;
      clr_mask_i = '0;
   endtask

   task automatic pop_check(input int idx, input int ts, input string req);
      check(log_valid_o == 1'b1, req, log_valid_o, 1);
      check(log_idx_o == 2'(idx), req, log_idx_o, idx);
      check(log_ts_o == 32'(ts), req, log_ts_o, ts);
      log_pop_i = 1'b1;
      @(negedge clk);
      log_pop_i = 1'b0;
   endtask

   function automatic int lowest(input logic [NF-1:0] m);
      for (int i = 0; i < NF; i++) if (m[i]) return i;
      return 0;
   endfunction

   initial begin
      #(PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int st;
      for (int i = 0; i < NF; i++) exp_cnt[i] = 0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R9: reset state
      check(irq_o == 1'b0, "R9 irq", irq_o, 0);
      check(svc_valid_o == 1'b0, "R9 svc", svc_valid_o, 0);
      check(log_valid_o == 1'b0, "R9 log", log_valid_o, 0);
      rd(0, d); check(d == 0, "R9 summary", d, 0);
      rd(2, d); check(d == 0, "R9 status", d, 0);
      for (int i = 0; i < NF; i++) begin
         rd(4 + i, d); check(d == 0, "R9 counter", d, 0);
      end

      // R5: timer and R8 latency
      rd_addr_i = 3'd1; t0 = cyc; step(1); d = rd_data_o;
      check(d == 32'(t0), "R5 R8 timer value", d, t0);
      step(6);
      rd_addr_i = 3'd1; t0 = cyc; step(1); d2 = rd_data_o;
      check(d2 - d == 32'd7, "R5 timer step", d2 - d, 7);
      rd(3, d); check(d == 0, "R8 unmapped", d, 0);

      // R1 R2 R3 R6 single pulse, interrupt gated
      pulse(4'b0100, st);
      check(svc_valid_o == 1'b1, "R3 valid", svc_valid_o, 1);
      check(svc_idx_o == 2'd2, "R3 index", svc_idx_o, 2);
      check(irq_o == 1'b0, "R2 masked", irq_o, 0);
      irq_en_i = 1'b1; #1;
      check(irq_o == 1'b1, "R2 enabled", irq_o, 1);
      step(2);
      pop_check(2, st, "R6 single");
      rd(0, d); check(d == 32'h4, "R1 summary", d, 4);
      clear(4'b0100);
      check(irq_o == 1'b0, "R2 after clear", irq_o, 0);
      rd(0, d); check(d == 0, "R1 cleared", d, 0);

      // R3 R6 R8 sweep of every simultaneous combination
      for (int m = 1; m < 16; m++) begin
         int pc;
         pc = $countones(4'(m));
         pulse(4'(m), st);
         step(5);
         check(svc_idx_o == 2'(lowest(4'(m))), "R3 sweep index", svc_idx_o, lowest(4'(m)));
         rd(0, d); check(d == 32'(m), "R1 sweep summary", d, m);
         rd(2, d); check(d[15:8] == 8'(pc), "R8 log count", d[15:8], pc);
         for (int i = 0; i < NF; i++) if (m[i]) pop_check(i, st, "R6 sweep order");
         check(log_valid_o == 1'b0, "R6 sweep empty", log_valid_o, 0);
         clear(4'(m));
      end

      // R1 partial clear and set-over-clear
      pulse(4'b1111, st);
      step(5);
      for (int i = 0; i < NF; i++) pop_check(i, st, "R6 all");
      clear(4'b0101);
      rd(0, d); check(d == 32'hA, "R1 partial clear", d, 10);
      atk_i = 4'b0010; clr_we_i = 1'b1; clr_mask_i = 4'b1010;
      exp_cnt[1]++; st = cyc;
      step(1);
      atk_i = '0; clr_we_i = 1'b0; clr_mask_i = '0;
      rd(0, d); check(d == 32'h2, "R1 set wins", d, 2);
      step(2);
      pop_check(1, st, "R6 set wins log");
      clear(4'b0010);

      // R4 counters
      for (int i = 0; i < NF; i++) begin
         rd(4 + i, d); check(d == 32'(exp_cnt[i]), "R4 counter", d, exp_cnt[i]);
      end

      // R10 drop of repeated pulse while staged
      rd(2, d); check(d[0] == 1'b0, "R7 ovf clear before", d[0], 0);
      atk_i = 4'b1111; st = cyc;
      for (int i = 0; i < NF; i++) exp_cnt[i]++;
      step(1);
      atk_i = 4'b1000; exp_cnt[3]++;
      step(1);
      atk_i = '0;
      step(5);
      rd(2, d);
      check(d[0] == 1'b1, "R10 overflow", d[0], 1);
      check(d[15:8] == 8'd4, "R10 log count", d[15:8], 4);
      for (int i = 0; i < NF; i++) pop_check(i, st, "R10 entries");
      rd(7, d); check(d == 32'(exp_cnt[3]), "R10 counted", d, exp_cnt[3]);
      ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;
      rd(2, d); check(d == 0, "R7 ovf cleared", d, 0);
      clear(4'b1111);

      // R7 fill past depth
      for (int k = 0; k < 20; k++) begin
         pulse(4'b0001, stamps[k]);
         step(2);
      end
      rd(2, d);
      check(d[0] == 1'b1, "R7 full overflow", d[0], 1);
      check(d[15:8] == 8'd16, "R7 depth", d[15:8], 16);
      for (int k = 0; k < 16; k++) pop_check(0, stamps[k], "R7 kept entries");
      check(log_valid_o == 1'b0, "R7 drained", log_valid_o, 0);
      step(3);
      rd(2, d); check(d == 32'h1, "R7 sticky", d, 1);
      ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;
      clear(4'b0001);

      // R4 saturation
      atk_i = 4'b0010;
      step(300);
      atk_i = '0;
      exp_cnt[1] = 255;
      step(4);
      rd(5, d); check(d == 32'd255, "R4 saturate", d, 255);
      rd(4, d); check(d == 32'(exp_cnt[0]), "R4 other unchanged", d, exp_cnt[0]);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule